// File: doc/BRIEF.md
# Multi-Channel Conversion Result Collector

This block gathers 18-bit results from eight parallel converter channels into one shared first-in first-out store. It then hands them out as 16-bit words on a shared backplane read bus. A transfer strobe, which arrives asynchronously, starts each capture. The strobe passes through a two-stage synchroniser and an edge detector before the block acts on it.

A mode input sets how the store is filled. In burst fill, one strobe edge queues all eight channels, lowest channel first, at one word per clock. In single fill, one strobe edge queues only the channel named by the three low bus address bits.

On the read side, the board answers when the four upper bus address bits equal its strapped board address. It drives its output enable while such a match exists and the store holds data. Each read taken while enabled removes one word. An alignment input chooses which 16 of the 18 stored bits reach the bus. A clear request empties the store.

Top module: `adc_frame_gather`

## Requirements
- R1: After reset, fifo_empty_o is 1 and fifo_full_o, overflow_o and bus_oe_o are 0.
- R2: With fill_mode_i = 0, a rising strobe edge queues channels 0, 1, … 7 in that order, one word per clock for eight consecutive clocks.
- R3: With fill_mode_i = 1, a rising strobe edge queues exactly one word: the channel whose number equals bus_addr_i[2:0] in the cycle the edge is detected.
- R4: bus_oe_o is 1 only when bus_addr_i[6:3] equals board_addr_i and the store is not empty; bus_addr_i[2:0] plays no part in this compare, and bus_data_o is 0 while bus_oe_o is 0.
- R5: bus_data_o carries bits [17:2] of the oldest stored word when lsb_align_i = 0, and bits [15:0] when lsb_align_i = 1; the choice applies when the word is presented.
- R6: A clock edge with bus_rd_i = 1 and bus_oe_o = 1 removes the oldest word; words leave in the order they were queued, and a read while bus_oe_o = 0 removes nothing.
- R7: The store holds 16 words, and fifo_full_o is 1 exactly when it holds 16. A write while it is full is dropped and sets overflow_o, which then stays 1 until a clear.
- R8: A rising edge on fifo_clear_i produces a one-clock internal pulse. The clock after that pulse, the store is empty, overflow_o is 0 and any burst in progress has stopped. The clear wins over a write in the same cycle.
- R9: A strobe edge detected while a burst is in progress is ignored, so the burst still queues exactly eight words.
- R10: A strobe held high for many clocks starts only one capture; a new capture needs the strobe to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_data_i | input | 144 | Eight 18-bit channel results, channel n at bits [18n+17:18n] |
| xfer_strobe_i | input | 1 | Asynchronous transfer strobe; its rising edge starts a capture |
| fill_mode_i | input | 1 | 0 = burst of all channels, 1 = single addressed channel |
| lsb_align_i | input | 1 | 0 = present bits [17:2], 1 = present bits [15:0] |
| fifo_clear_i | input | 1 | Clear request; its rising edge empties the store |
| board_addr_i | input | 4 | Strapped board address |
| bus_addr_i | input | 7 | Backplane address: [6:3] board compare, [2:0] channel select |
| bus_rd_i | input | 1 | Read strobe; removes one word when the output is enabled |
| bus_data_o | output | 16 | Read data word |
| bus_oe_o | output | 1 | Bus drive enable |
| fifo_full_o | output | 1 | Store holds 16 words |
| fifo_empty_o | output | 1 | Store holds no words |
| overflow_o | output | 1 | Sticky flag: a write was dropped while full |

## Verification
The hardest case to reach from the ports is a second strobe edge that lands inside a running burst. The strobe is pulsed, dropped for two clocks and raised again, so the second edge reaches the synchroniser output while the sequencer is still stepping through channels. Overflow is reached by firing three bursts with no reads in between. The expected queue then drops every word past the sixteenth, and the sticky flag is checked again after draining.

// File: rtl/gather_pkg.sv
package gather_pkg;

    localparam int SAMPLE_W     = 18;
    localparam int BUS_W        = 16;
    localparam int NUM_CH       = 8;
    localparam int CH_SEL_W     = $clog2(NUM_CH);
    localparam int BOARD_ADDR_W = 4;
    localparam int BUS_ADDR_W   = BOARD_ADDR_W + CH_SEL_W;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CH_SEL_W-1:0] ch_sel_t;

    typedef enum logic {
        FILL_BURST  = 1'b0,
        FILL_SINGLE = 1'b1
    } fill_mode_e;

    typedef enum logic {
        ALIGN_HIGH = 1'b0,
        ALIGN_LOW  = 1'b1
    } align_e;

    typedef struct packed {
        logic    push;
        ch_sel_t ch;
    } cap_req_t;

    function automatic logic [BUS_W-1:0] bus_window(sample_t s, align_e a);
        if (a == ALIGN_LOW)
            return s[BUS_W-1:0];
        else
            return s[SAMPLE_W-1 -: BUS_W];
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else
            shift_q <= {shift_q[STAGES-1:0], async_i};
    end

    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/capture_seq.sv
module capture_seq
    import gather_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort_i,
    input  logic       start_i,
    input  fill_mode_e mode_i,
    input  ch_sel_t    sel_i,
    output cap_req_t   req_o,
    output logic       busy_o
);
    logic    busy_q;
    ch_sel_t idx_q;

    always_comb begin
        req_o = '0;
        if (busy_q) begin
            req_o.push = 1'b1;
            req_o.ch   = idx_q;
        end else if (start_i) begin
            req_o.push = 1'b1;
            req_o.ch   = (mode_i == FILL_SINGLE) ? sel_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (idx_q == ch_sel_t'(NUM_CH - 1)) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (start_i && mode_i == FILL_BURST) begin
            busy_q <= 1'b1;
            idx_q  <= ch_sel_t'(1);
        end
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             overflow_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             ovf_q;
    logic             push_ok, pop_ok;

    assign full_o  = (count_q == CW'(DEPTH));
    assign empty_o = (count_q == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !clr_i)
            mem[wr_ptr_q] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr_q <= next_ptr(wr_ptr_q);
            if (pop_ok)
                rd_ptr_q <= next_ptr(rd_ptr_q);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (push_i && full_o)
                ovf_q <= 1'b1;
        end
    end

    assign head_o     = mem[rd_ptr_q];
    assign overflow_o = ovf_q;
endmodule

// File: rtl/bus_port.sv
module bus_port
    import gather_pkg::*;
(
    input  logic [BOARD_ADDR_W-1:0] board_addr_i,
    input  logic [BOARD_ADDR_W-1:0] bus_board_i,
    input  logic                    empty_i,
    input  sample_t                 head_i,
    input  align_e                  align_i,
    input  logic                    rd_i,
    output logic                    oe_o,
    output logic [BUS_W-1:0]        data_o,
    output logic                    pop_o
);
    logic match;

    assign match  = (bus_board_i == board_addr_i);
    assign oe_o   = match && !empty_i;
    assign data_o = oe_o ? bus_window(head_i, align_i) : '0;
    assign pop_o  = rd_i && oe_o;
endmodule

// File: rtl/adc_frame_gather.sv
module adc_frame_gather
    import gather_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CH*SAMPLE_W-1:0]   conv_data_i,
    input  logic                         xfer_strobe_i,
    input  logic                         fill_mode_i,
    input  logic                         lsb_align_i,
    input  logic                         fifo_clear_i,
    input  logic [BOARD_ADDR_W-1:0]      board_addr_i,
    input  logic [BUS_ADDR_W-1:0]        bus_addr_i,
    input  logic                         bus_rd_i,
    output logic [BUS_W-1:0]             bus_data_o,
    output logic                         bus_oe_o,
    output logic                         fifo_full_o,
    output logic                         fifo_empty_o,
    output logic                         overflow_o
);
    sample_t  ch_data [NUM_CH];
    logic     strobe_edge;
    logic     seq_busy;
    logic     seq_push;
    cap_req_t cap_req;
    logic     clr_req_q;
    logic     clr_pulse;
    sample_t  fifo_head;
    logic     fifo_pop;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_split
        assign ch_data[g] = conv_data_i[g*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_req_q <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            clr_req_q <= fifo_clear_i;
            clr_pulse <= fifo_clear_i && !clr_req_q;
        end
    end

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (xfer_strobe_i),
        .rise_o  (strobe_edge)
    );

    capture_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .abort_i (clr_pulse),
        .start_i (strobe_edge),
        .mode_i  (fill_mode_e'(fill_mode_i)),
        .sel_i   (bus_addr_i[CH_SEL_W-1:0]),
        .req_o   (cap_req),
        .busy_o  (seq_busy)
    );

    assign seq_push = cap_req.push;

    word_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_pulse),
        .push_i     (seq_push),
        .wdata_i    (ch_data[cap_req.ch]),
        .pop_i      (fifo_pop),
        .head_o     (fifo_head),
        .full_o     (fifo_full_o),
        .empty_o    (fifo_empty_o),
        .overflow_o (overflow_o)
    );

    bus_port u_port (
        .board_addr_i (board_addr_i),
        .bus_board_i  (bus_addr_i[BUS_ADDR_W-1:CH_SEL_W]),
        .empty_i      (fifo_empty_o),
        .head_i       (fifo_head),
        .align_i      (align_e'(lsb_align_i)),
        .rd_i         (bus_rd_i),
        .oe_o         (bus_oe_o),
        .data_o       (bus_data_o),
        .pop_o        (fifo_pop)
    );
endmodule

// File: rtl/gather_checker.sv
module gather_checker
    import gather_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    full,
    input logic                    empty,
    input logic                    overflow,
    input logic                    oe,
    input logic [BOARD_ADDR_W-1:0] board_addr,
    input logic [BUS_ADDR_W-1:0]   bus_addr,
    input logic                    strobe_edge,
    input logic                    busy,
    input logic                    push,
    input logic                    clr_pulse
);
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (rst)
        overflow && !clr_pulse |=> overflow);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> empty && !overflow && !busy);

    assert_oe_needs_match_R4: assert property (@(posedge clk) disable iff (rst)
        oe |-> (bus_addr[BUS_ADDR_W-1:CH_SEL_W] == board_addr) && !empty);

    assert_burst_from_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(strobe_edge));

    assert_burst_every_clock_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> push);
endmodule

bind adc_frame_gather gather_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .full        (fifo_full_o),
    .empty       (fifo_empty_o),
    .overflow    (overflow_o),
    .oe          (bus_oe_o),
    .board_addr  (board_addr_i),
    .bus_addr    (bus_addr_i),
    .strobe_edge (strobe_edge),
    .busy        (seq_busy),
    .push        (seq_push),
    .clr_pulse   (clr_pulse)
);

// File: tb/adc_frame_gather_test.sv
`timescale 1ns/100ps
module adc_frame_gather_test;
    import gather_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NUM_CH*SAMPLE_W-1:0] conv_data = '0;
    logic                       strobe = 1'b0;
    logic                       mode = 1'b0;
    logic                       lsb = 1'b0;
    logic                       clr = 1'b0;
    logic [3:0]                 board = 4'h5;
    logic [6:0]                 addr = '0;
    logic                       rd = 1'b0;
    logic [15:0]                bus_data;
    logic                       bus_oe, full, empty, ovf;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [17:0] exp_q [$];
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    adc_frame_gather uut (
        .clk (clk), .rst (rst), .conv_data_i (conv_data),
        .xfer_strobe_i (strobe), .fill_mode_i (mode), .lsb_align_i (lsb),
        .fifo_clear_i (clr), .board_addr_i (board), .bus_addr_i (addr),
        .bus_rd_i (rd), .bus_data_o (bus_data), .bus_oe_o (bus_oe),
        .fifo_full_o (full), .fifo_empty_o (empty), .overflow_o (ovf)
    );

    function automatic logic [17:0] pat(int ch, int seed);
        return 18'(seed * 18'h1357 + ch * 18'h2A5D + 18'h15A3);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(int seed);
        for (int c = 0; c < NUM_CH; c++)
            conv_data[c*SAMPLE_W +: SAMPLE_W] = pat(c, seed);
    endtask

    task automatic model_push(int ch, int seed);
        if (exp_q.size() < 16) exp_q.push_back(pat(ch, seed));
    endtask

    // driver: fires a strobe and queues the expected words
    task automatic fire(bit single, int ch, int seed, int hold);
        @(negedge clk);
        load(seed);
        mode = single;
        addr = {4'hA, 3'(ch)};
        strobe = 1'b1;
        repeat (hold) @(negedge clk);
        strobe = 1'b0;
        if (single) model_push(ch, seed);
        else for (int c = 0; c < NUM_CH; c++) model_push(c, seed);
        repeat (12) @(negedge clk);
    endtask

    task automatic drain(int n, string req);
        cur_req = req;
        @(negedge clk);
        addr = {board, 3'b110};
        rd = 1'b1;
        repeat (n) @(negedge clk);
        rd = 1'b0;
    endtask

    // monitor: compares each accepted read against the queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rd && bus_oe) begin
                if (exp_q.size() == 0) begin
                    chk(cur_req, {16'h0, bus_data}, 32'hDEAD);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    chk(cur_req, {16'h0, bus_data},
                        {16'h0, lsb ? e[15:0] : e[17:2]});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", empty, 1); chk("R1", full, 0); chk("R1", ovf, 0); chk("R1", bus_oe, 0);

        // R2 burst, high alignment; R4 mismatch keeps oe low
        fire(1'b0, 0, 1, 3);
        addr = {4'h3, 3'b000};
        #1 chk("R4", bus_oe, 0); chk("R4", bus_data, 0);
        addr = {board, 3'b011};
        #1 chk("R4", bus_oe, 1);
        drain(8, "R2");
        #1 chk("R6", empty, 1);

        // R5 low alignment
        lsb = 1'b1;
        fire(1'b0, 0, 2, 3);
        drain(8, "R5");
        lsb = 1'b0;

        // R3 single mode
        fire(1'b1, 5, 3, 3);
        fire(1'b1, 2, 4, 3);
        drain(2, "R3");
        #1 chk("R3", empty, 1);

        // R6 read while not addressed removes nothing
        fire(1'b0, 0, 5, 3);
        @(negedge clk);
        addr = {4'h0, 3'b101};
        rd = 1'b1;
        repeat (3) @(negedge clk);
        rd = 1'b0;
        drain(8, "R6");
        #1 chk("R6", empty, 1);

        // R10 held strobe captures once
        fire(1'b0, 0, 6, 30);
        chk("R10", full, 0);
        drain(8, "R10");
        #1 chk("R10", empty, 1);

        // R9 second edge inside a burst
        @(negedge clk);
        load(7); mode = 1'b0; strobe = 1'b1;
        repeat (2) @(negedge clk); strobe = 1'b0;
        repeat (2) @(negedge clk); strobe = 1'b1;
        repeat (2) @(negedge clk); strobe = 1'b0;
        for (int c = 0; c < NUM_CH; c++) model_push(c, 7);
        repeat (14) @(negedge clk);
        drain(8, "R9");
        #1 chk("R9", empty, 1);

        // R7 overflow
        fire(1'b0, 0, 8, 3);
        fire(1'b0, 0, 9, 3);
        fire(1'b0, 0, 10, 3);
        chk("R7", full, 1); chk("R7", ovf, 1);
        drain(16, "R7");
        #1 chk("R7", empty, 1); chk("R7", ovf, 1);

        // R8 clear
        fire(1'b0, 0, 11, 3);
        @(negedge clk);
        clr = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        exp_q.delete();
        addr = {board, 3'b000};
        #1 chk("R8", empty, 1); chk("R8", ovf, 0); chk("R8", bus_oe, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule